// File: doc/BRIEF.md
# Keyed Flash Command Register

This block is the command and status register that software writes to launch an operation on nonvolatile memory. A single 32-bit register-bus write carries a 16-bit unlock key in its upper half and one command bit in its low nibble. The four commands are program-word, page-erase, whole-array erase and commit. When the write is accepted, the block samples the target address and program data from the neighbouring address and data registers. It then emits a one-cycle start pulse toward the flash array controller, carrying a 2-bit operation code and those sampled values.

Each command bit then reads back as a busy flag for its own operation. The flag clears itself when the array controller returns its one-cycle done pulse. If done never arrives, a watchdog counter clears the flag after a parameterised number of cycles and raises a sticky timeout flag. Writes with a wrong key are dropped. So are writes issued while an operation is running. A write that names more than one command starts nothing and raises a sticky error flag.

Top module: `flash_cmd_reg`

## Requirements
- R1: A bus write is considered only when bits 31:16 equal 0xA442; any other key value is ignored completely: no start pulse, no busy bit, no error flag.
- R2: Bits 31:16 and 15:4 of the read data are always zero. Bits 3:0 are the busy flags, bit 0 program, bit 1 erase, bit 2 whole-array erase, bit 3 commit.
- R3: A keyed write with exactly one command bit set while idle gives, in the cycle after the write, a one-cycle `cmd_start`. `cmd_op` equals the bit index (0 program, 1 erase, 2 whole-array erase, 3 commit). `cmd_addr`/`cmd_data` carry the `addr_in`/`data_in` values present during the write, and the matching busy bit is set.
- R4: A busy bit stays 1 until the operation ends; a `cmd_done` pulse while busy clears it at the next clock edge.
- R5: A keyed write whose command bits are all zero changes nothing; in particular it cannot cancel a running operation.
- R6: While any busy bit is set, every command write is ignored: no new start pulse and no change to the busy bits.
- R7: A keyed write while idle with two or more command bits set starts nothing and sets the sticky `err_multi` flag.
- R8: If an operation stays busy for TIMEOUT_CYC cycles without done, its busy bit clears and the sticky `err_timeout` flag is set.
- R9: Synchronous reset clears all busy bits, `cmd_start`, `err_multi` and `err_timeout`.
- R10: A `cmd_done` pulse while idle has no effect on the busy bits or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data: key in 31:16, command bits in 3:0 |
| bus_rdata | output | 32 | Read data: busy flags in 3:0, rest zero |
| addr_in | input | ADDR_W | Target address from the address register |
| data_in | input | DATA_W | Program data from the data register |
| cmd_start | output | 1 | One-cycle operation start pulse |
| cmd_op | output | 2 | Operation code sent with the start pulse |
| cmd_addr | output | ADDR_W | Address sampled at acceptance |
| cmd_data | output | DATA_W | Data sampled at acceptance |
| cmd_done | input | 1 | One-cycle completion pulse from the array controller |
| err_multi | output | 1 | Sticky flag: multiple command bits written |
| err_timeout | output | 1 | Sticky flag: watchdog expired |

## Verification
The assertions assume that `cmd_done` is a single-cycle pulse and arrives only while an operation is outstanding, at most once per operation. They also assume that `bus_wr` is a one-cycle strobe. The bench drives done only through a task that raises it for exactly one cycle after a start it has already observed. It also issues a deliberate idle done to cover R10, where the checks look only at the ports. The bench shortens the watchdog limit so that the timeout path is reached within a short run.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int NUM_OPS = 4;
  localparam logic [15:0] CMD_KEY = 16'hA442;

  typedef enum logic [1:0] {
    OP_PROGRAM = 2'd0,
    OP_ERASE   = 2'd1,
    OP_MASS    = 2'd2,
    OP_COMMIT  = 2'd3
  } flash_op_e;

  function automatic logic [NUM_OPS-1:0] op_to_mask(input flash_op_e op);
    op_to_mask = NUM_OPS'(1) << op;
  endfunction
endpackage

// File: rtl/flash_key_decode.sv
module flash_key_decode
  import flash_cmd_pkg::*;
(
  input  logic               wr_en,
  input  logic [15:0]        key_field,
  input  logic [NUM_OPS-1:0] cmd_bits,
  input  logic               busy_any,
  output logic               go,
  output flash_op_e          go_op,
  output logic               multi
);
  logic key_ok;
  logic accepted;
  int   n_set;

  assign key_ok   = (key_field == CMD_KEY);
  assign accepted = wr_en && key_ok && !busy_any;

  always_comb begin
    n_set = 0;
    go_op = OP_PROGRAM;
    for (int i = 0; i < NUM_OPS; i++) begin
      if (cmd_bits[i]) begin
        n_set = n_set + 1;
        go_op = flash_op_e'(i[1:0]);
      end
    end
  end

  assign go    = accepted && (n_set == 1);
  assign multi = accepted && (n_set > 1);
endmodule

// File: rtl/flash_op_tracker.sv
module flash_op_tracker
  import flash_cmd_pkg::*;
#(
  parameter int TIMEOUT_CYC = 12_500_000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  flash_op_e          go_op,
  input  logic               done,
  output logic [NUM_OPS-1:0] busy,
  output logic               timeout_flag
);
  localparam int CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] wd_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy         <= '0;
      wd_cnt       <= '0;
      timeout_flag <= 1'b0;
    end else if (go) begin
      busy   <= op_to_mask(go_op);
      wd_cnt <= '0;
    end else if (|busy) begin
      if (done) begin
        busy <= '0;
      end else if (wd_cnt == CNT_LAST) begin
        busy         <= '0;
        timeout_flag <= 1'b1;
      end else begin
        wd_cnt <= wd_cnt + 1'b1;
      end
    end
  end

  assert_busy_onehot0_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(busy));
  assert_done_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (done && (|busy) && !go) |=> (busy == '0));
  assert_go_sets_bit_R3: assert property (@(posedge clk) disable iff (rst)
    go |=> (busy == op_to_mask($past(go_op))));
  assert_timeout_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    timeout_flag |=> timeout_flag);
  assert_idle_done_R10: assert property (@(posedge clk) disable iff (rst)
    ((busy == '0) && !go) |=> (busy == '0));
endmodule

// File: rtl/flash_cmd_issue.sv
module flash_cmd_issue
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  flash_op_e         go_op,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              start,
  output logic [1:0]        op,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      start <= 1'b0;
      op    <= 2'd0;
      addr  <= '0;
      data  <= '0;
    end else begin
      start <= go;
      if (go) begin
        op   <= go_op;
        addr <= addr_in;
        data <= data_in;
      end
    end
  end

  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);
  assert_start_follows_go_R3: assert property (@(posedge clk) disable iff (rst)
    go |=> (start && (op == $past(go_op)) && (addr == $past(addr_in))));
endmodule

// File: rtl/flash_cmd_reg.sv
module flash_cmd_reg
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 32,
  parameter int TIMEOUT_CYC = 12_500_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              cmd_start,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_done,
  output logic              err_multi,
  output logic              err_timeout
);
  logic               go;
  logic               multi;
  flash_op_e          go_op;
  logic [NUM_OPS-1:0] busy;
  logic               unused_rsvd;

  assign unused_rsvd = ^bus_wdata[15:NUM_OPS];

  flash_key_decode u_decode (
    .wr_en    (bus_wr),
    .key_field(bus_wdata[31:16]),
    .cmd_bits (bus_wdata[NUM_OPS-1:0]),
    .busy_any (|busy),
    .go       (go),
    .go_op    (go_op),
    .multi    (multi)
  );

  flash_op_tracker #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tracker (
    .clk         (clk),
    .rst         (rst),
    .go          (go),
    .go_op       (go_op),
    .done        (cmd_done),
    .busy        (busy),
    .timeout_flag(err_timeout)
  );

  flash_cmd_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_issue (
    .clk    (clk),
    .rst    (rst),
    .go     (go),
    .go_op  (go_op),
    .addr_in(addr_in),
    .data_in(data_in),
    .start  (cmd_start),
    .op     (cmd_op),
    .addr   (cmd_addr),
    .data   (cmd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) err_multi <= 1'b0;
    else if (multi) err_multi <= 1'b1;
  end

  assign bus_rdata = {16'h0000, {(16-NUM_OPS){1'b0}}, busy};

  assert_badkey_ignored_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_wdata[31:16] != CMD_KEY) && (busy == '0))
      |=> (!cmd_start && (busy == '0) && (err_multi == $past(err_multi))));
  assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (|busy)) |=> !cmd_start);
  assert_multi_no_start_R7: assert property (@(posedge clk) disable iff (rst)
    multi |=> (!cmd_start && err_multi));
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err_multi |=> err_multi);
endmodule

// File: tb/flash_cmd_reg_tb.sv
module flash_cmd_reg_tb;
  localparam int AW = 24;
  localparam int DW = 32;
  localparam int TO = 64;
  localparam logic [15:0] KEY = 16'hA442;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] data_in = '0;
  logic          cmd_start;
  logic [1:0]    cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  logic          cmd_done = 1'b0;
  logic          err_multi;
  logic          err_timeout;

  int checks = 0;
  int errors = 0;
  logic [2+AW+DW-1:0] exp_q[$];

  always #10 clk = ~clk;

  flash_cmd_reg #(.ADDR_W(AW), .DATA_W(DW), .TIMEOUT_CYC(TO)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .addr_in(addr_in), .data_in(data_in),
    .cmd_start(cmd_start), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_done(cmd_done), .err_multi(err_multi),
    .err_timeout(err_timeout)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && cmd_start) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3 unexpected start actual=%0h expected=none",
                 {cmd_op, cmd_addr, cmd_data});
      end else begin
        logic [2+AW+DW-1:0] e;
        e = exp_q.pop_front();
        if ({cmd_op, cmd_addr, cmd_data} !== e) begin
          errors++;
          $display("FAIL R3 start fields actual=%0h expected=%0h",
                   {cmd_op, cmd_addr, cmd_data}, e);
        end
      end
    end
  end

  task automatic bus_write(input logic [31:0] w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = w; addr_in = a; data_in = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; addr_in = ~a; data_in = ~d;
  endtask

  task automatic start_op(input int bitn, input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_q.push_back({2'(bitn), a, d});
    bus_write({KEY, 12'h000, 4'(1 << bitn)}, a, d);
  endtask

  task automatic pulse_done();
    @(negedge clk); cmd_done = 1'b1;
    @(negedge clk); cmd_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 rdata", 64'(bus_rdata), 64'h0);
    check("R9 flags", {62'h0, err_multi, err_timeout}, 64'h0);
    check("R9 start", 64'(cmd_start), 64'h0);

    // R1 wrong key
    bus_write({16'hA443, 16'h0001}, 24'h000100, 32'h11111111);
    check("R1 wrong key busy", 64'(bus_rdata), 64'h0);
    bus_write({16'h0000, 16'h0006}, 24'h000100, 32'h11111111);
    check("R1 wrong key multi no err", 64'(err_multi), 64'h0);

    // R3 program
    start_op(0, 24'h123456, 32'hDEADBEEF);
    check("R3 program busy", 64'(bus_rdata), 64'h1);
    // R5 zero command
    bus_write({KEY, 16'h0000}, 24'h0, 32'h0);
    check("R5 zero write keeps busy", 64'(bus_rdata), 64'h1);
    // R6 while busy
    bus_write({KEY, 16'h0002}, 24'h0, 32'h0);
    check("R6 busy ignores write", 64'(bus_rdata), 64'h1);
    // R2 reserved/key readback
    bus_write({KEY, 16'hFFF0}, 24'h0, 32'h0);
    check("R2 readback upper zero", 64'(bus_rdata[31:4]), 64'h0);
    repeat (5) @(negedge clk);
    check("R4 still busy before done", 64'(bus_rdata), 64'h1);
    pulse_done();
    check("R4 done clears", 64'(bus_rdata), 64'h0);

    start_op(1, 24'h00ABCD, 32'h01020304);
    check("R3 erase busy", 64'(bus_rdata), 64'h2);
    pulse_done();
    check("R4 erase done", 64'(bus_rdata), 64'h0);
    start_op(2, 24'hFFFFFF, 32'h0);
    check("R3 mass busy", 64'(bus_rdata), 64'h4);
    repeat (10) @(negedge clk);
    pulse_done();
    check("R4 mass done", 64'(bus_rdata), 64'h0);
    start_op(3, 24'h000004, 32'hCAFEF00D);
    check("R3 commit busy", 64'(bus_rdata), 64'h8);
    pulse_done();
    check("R4 commit done", 64'(bus_rdata), 64'h0);

    // R7 multiple bits
    bus_write({KEY, 16'h0003}, 24'h0, 32'h0);
    check("R7 multi no busy", 64'(bus_rdata), 64'h0);
    check("R7 multi err", 64'(err_multi), 64'h1);
    start_op(0, 24'h000010, 32'h55AA55AA);
    check("R7 err sticky", 64'(err_multi), 64'h1);
    pulse_done();

    // R10 idle done
    pulse_done();
    check("R10 idle done", {bus_rdata, 30'h0, err_timeout, err_multi}, {32'h0, 30'h0, 1'b0, 1'b1});

    // R8 watchdog
    start_op(2, 24'h000020, 32'h0);
    repeat (TO - 1) @(negedge clk);
    check("R8 busy before limit", {62'(bus_rdata), err_timeout}, {62'h4, 1'b0});
    @(negedge clk);
    check("R8 cleared at limit", {62'(bus_rdata), err_timeout}, {62'h0, 1'b1});
    start_op(1, 24'h000030, 32'h0);
    check("R8 new op after timeout", 64'(bus_rdata), 64'h2);

    // R9 reset mid-operation
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R9 mid reset", {bus_rdata, 29'h0, cmd_start, err_multi, err_timeout}, 64'h0);

    repeat (3) @(negedge clk);
    check("R3 all starts seen", 64'(exp_q.size()), 64'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule